// File: doc/BRIEF.md
# Track Parity Stripper and Bus Interleaver

This block takes parallel serial track streams from a formatter (32 or 64 tracks, one bit per track per formatter bit strobe, bit rate at most 18 MHz) and turns them into 32-bit words for a 32-line data bus. Each track carries groups of nine bits: eight data bits followed by one parity bit. The block drops the parity bit on all tracks at once. A frame-start input puts every track on the same group alignment.

In 32-track mode each data bit period yields one word, and bus line k carries track k. In 64-track mode each data bit period yields two words: track 2k goes to line k in the first word, and track 2k+1 goes to line k in the second. The average word rate is therefore 8/9 (32 tracks) or 16/9 (64 tracks) of the formatter bit rate. A 16-entry elastic FIFO smooths the gapped stream. The FIFO has an almost-full flag and a sticky overflow flag.

The control state machine has three states. ST_IDLE ignores track bits and accepts configuration writes. It goes to ST_RUN when `run` is high, and to ST_FLUSH on an accepted configuration write. ST_RUN gathers bits and returns to ST_IDLE when `run` falls. ST_FLUSH lasts one cycle: it empties the FIFO, clears the group phase and the pending odd word, and then always returns to ST_IDLE.

Top module: `trk_strip_pack`

## Requirements
- R1: After reset, `word_vld`, `fifo_afull`, `ovf_err` and `cfg_rej` are 0, and `mode_is64` is 0 (32-track mode).
- R2: A `cfg_wr` with `cfg_tracks` equal to 32 or 64 while in ST_IDLE sets `mode_is64` (1 for 64). Any other count, or any write outside ST_IDLE, leaves the mode unchanged and raises `cfg_rej` for one cycle, in the cycle after the write.
- R3: A group phase counts 0 to 8 on each accepted bit, and the bit at phase 8 is the parity bit and yields no word. A bit that comes with `frame_start` has phase 0.
- R4: In 32-track mode each non-parity bit pushes one word whose bit k equals track k. Tracks 32 to 63 have no effect.
- R5: In 64-track mode each non-parity bit pushes two words, in consecutive cycles. In the first word bit k equals track 2k; in the second, bit k equals track 2k+1.
- R6: Track bits are ignored outside ST_RUN.
- R7: Words leave in the order they were pushed. `word_vld` is high while the FIFO holds a word, and a word is removed on a cycle where both `word_vld` and `word_rdy` are high.
- R8: `fifo_afull` is high while the FIFO holds 14 or more words.
- R9: A push into a full FIFO that is not being read is dropped. `ovf_err` then stays high until reset; an accepted configuration does not clear it.
- R10: An accepted configuration write empties the FIFO and resets the group phase, so that the next bit has phase 0.
- R11: ST_FLUSH lasts exactly one cycle and is followed by ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_tracks | input | 7 | Requested track count |
| run | input | 1 | High to gather bits |
| bit_en | input | 1 | One-cycle strobe per formatter bit |
| frame_start | input | 1 | Marks the bit as group phase 0 |
| trk_in | input | 64 | One bit per track |
| word_rdy | input | 1 | Consumer takes the head word |
| word_vld | output | 1 | FIFO holds a word |
| word_data | output | 32 | Head word |
| fifo_afull | output | 1 | FIFO holds 14 or more words |
| ovf_err | output | 1 | Sticky overflow flag |
| mode_is64 | output | 1 | 1 for 64-track mode |
| cfg_rej | output | 1 | Last configuration write was refused |

## Verification
Vector runs use a different pseudo-random track pattern in each mode, with the upper 32 tracks always busy. A swapped lane mapping, a leak of the upper tracks in 32-track mode, or the odd and even words in the wrong order would each change the compared words. Runs of 18 bits span two parity slots, so a parity bit that is kept or a data bit that is dropped shows up as both a word mismatch and a wrong word count. Directed sequences fill the FIFO word by word across the 14-word and 16-word thresholds. They also restart a group in mid-byte with `frame_start`, and begin a run after a flush without `frame_start`, which separates a phase reset from a counter that merely carries on.

// File: rtl/trk_pkg.sv
package trk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } trk_state_e;

    localparam int unsigned GROUP_BITS = 9;
endpackage

// File: rtl/trk_phase.sv
module trk_phase #(
    parameter int unsigned GROUP = 9,
    localparam int unsigned PW = $clog2(GROUP),
    localparam int unsigned LAST = GROUP - 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic restart,
    output logic is_par
);
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] cur;

    always_comb begin
        cur    = restart ? '0 : cnt_q;
        is_par = (cur == PW'(LAST));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (step) cnt_q <= (cur == PW'(LAST)) ? '0 : cur + 1'b1;
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PW'(LAST)); // R3
endmodule

// File: rtl/trk_fifo.sv
module trk_fifo #(
    parameter int unsigned W = 32,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AF_LVL = DEPTH - 2,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         nonempty,
    output logic         afull,
    output logic         ovf
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          rd_ok, wr_ok;

    always_comb begin
        rd_ok    = rd && (cnt_q != '0);
        wr_ok    = wr && ((cnt_q != CW'(DEPTH)) || rd_ok);
        rdata    = mem[rp_q];
        nonempty = (cnt_q != '0);
        afull    = (cnt_q >= CW'(AF_LVL));
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else if (clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ok) wp_q <= wp_q + 1'b1;
            if (rd_ok) rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
            if (wr && !wr_ok) ovf <= 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr && !rd) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/trk_strip_pack.sv
module trk_strip_pack #(
    parameter int unsigned LINES = 32,
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned TRACKS_MAX = 2 * LINES,
    localparam int unsigned TW = $clog2(TRACKS_MAX + 1),
    localparam int unsigned AFULL_LVL = FIFO_DEPTH - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [TW-1:0]         cfg_tracks,
    input  logic                  run,
    input  logic                  bit_en,
    input  logic                  frame_start,
    input  logic [TRACKS_MAX-1:0] trk_in,
    input  logic                  word_rdy,
    output logic                  word_vld,
    output logic [LINES-1:0]      word_data,
    output logic                  fifo_afull,
    output logic                  ovf_err,
    output logic                  mode_is64,
    output logic                  cfg_rej
);
    import trk_pkg::*;

    trk_state_e       state_q, state_d;
    logic             mode64_q;
    logic             rej_q;
    logic             pend_q;
    logic [LINES-1:0] pend_w_q;
    logic [LINES-1:0] even_w, odd_w;
    logic             cfg_ok, take, flush, is_par, data_bit, push;
    logic [LINES-1:0] push_w;

    for (genvar k = 0; k < LINES; k++) begin : g_lane
        assign even_w[k] = trk_in[2*k];
        assign odd_w[k]  = trk_in[2*k+1];
    end

    always_comb begin
        cfg_ok = cfg_wr && (state_q == ST_IDLE) &&
                 ((cfg_tracks == TW'(LINES)) || (cfg_tracks == TW'(TRACKS_MAX)));
        take   = (state_q == ST_RUN) && bit_en;
        flush  = (state_q == ST_FLUSH);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cfg_ok) state_d = ST_FLUSH;
                      else if (run) state_d = ST_RUN;
            ST_RUN:   if (!run) state_d = ST_IDLE;
            ST_FLUSH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    trk_phase #(.GROUP(GROUP_BITS)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(flush), .step(take),
        .restart(frame_start), .is_par(is_par)
    );

    always_comb begin
        data_bit = take && !is_par;
        push     = pend_q || data_bit;
        if (pend_q)        push_w = pend_w_q;
        else if (mode64_q) push_w = even_w;
        else               push_w = trk_in[LINES-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode64_q <= 1'b0;
            rej_q    <= 1'b0;
            pend_q   <= 1'b0;
            pend_w_q <= '0;
        end else begin
            rej_q <= cfg_wr && !cfg_ok;
            if (cfg_ok) mode64_q <= (cfg_tracks == TW'(TRACKS_MAX));
            if (flush) begin
                pend_q <= 1'b0;
            end else if (data_bit && mode64_q) begin
                pend_q   <= 1'b1;
                pend_w_q <= odd_w;
            end else begin
                pend_q <= 1'b0;
            end
        end
    end

    trk_fifo #(.W(LINES), .DEPTH(FIFO_DEPTH), .AF_LVL(AFULL_LVL)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(flush), .wr(push), .wdata(push_w),
        .rd(word_rdy), .rdata(word_data), .nonempty(word_vld),
        .afull(fifo_afull), .ovf(ovf_err)
    );

    always_comb begin
        mode_is64 = mode64_q;
        cfg_rej   = rej_q;
    end

    AST_MODE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(mode64_q)); // R2
    AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (state_q == ST_IDLE)); // R11
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> !word_vld); // R10
    AST_PARITY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_par && !pend_q) |-> !push); // R3
    AST_IDLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !pend_q) |-> !push); // R6
endmodule

// File: tb/trk_strip_pack_tb.sv
module trk_strip_pack_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [6:0]  cfg_tracks = '0;
    logic        run = 1'b0;
    logic        bit_en = 1'b0;
    logic        frame_start = 1'b0;
    logic [63:0] trk_in = '0;
    logic        word_rdy = 1'b0;
    logic        word_vld, fifo_afull, ovf_err, mode_is64, cfg_rej;
    logic [31:0] word_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_w [0:255];
    int exp_n = 0;
    int mon_rd = 0;
    int ph = 0;
    bit tb_m64 = 1'b0;

    always #2 clk = ~clk;

    trk_strip_pack u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_tracks(cfg_tracks),
        .run(run), .bit_en(bit_en), .frame_start(frame_start), .trk_in(trk_in),
        .word_rdy(word_rdy), .word_vld(word_vld), .word_data(word_data),
        .fifo_afull(fifo_afull), .ovf_err(ovf_err), .mode_is64(mode_is64),
        .cfg_rej(cfg_rej)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R7 monitor: compares each popped word in order
    always @(negedge clk) begin
        if (rst_n && word_vld && word_rdy) begin
            if (mon_rd < exp_n)
                chk(word_data == exp_w[mon_rd], "R4/R5/R7 word", word_data, exp_w[mon_rd]);
            else
                chk(1'b0, "R7 unexpected word", word_data, 0);
            mon_rd++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [63:0] pat(input int seed, input int b);
        logic [31:0] lo, hi;
        lo = (32'(seed) * 32'h9E3779B1) ^ (32'(b) * 32'h01000193) ^ {8'(b), 24'h5A3C1};
        hi = (lo * 32'h2545F491) ^ 32'hA5A50F0F;
        return {hi, lo};
    endfunction

    // bench model of R3/R4/R5
    task automatic send_bit(input logic [63:0] t, input bit fs);
        if (fs) ph = 0;
        if (ph != 8) begin
            if (tb_m64) begin
                logic [31:0] ev, od;
                for (int k = 0; k < 32; k++) begin
                    ev[k] = t[2*k];
                    od[k] = t[2*k+1];
                end
                exp_w[exp_n] = ev; exp_n++;
                exp_w[exp_n] = od; exp_n++;
            end else begin
                exp_w[exp_n] = t[31:0]; exp_n++;
            end
        end
        ph = (ph == 8) ? 0 : ph + 1;
        trk_in = t; bit_en = 1'b1; frame_start = fs;
        tick();
        bit_en = 1'b0; frame_start = 1'b0;
        tick(); tick(); tick();
    endtask

    task automatic do_cfg(input int tracks);
        cfg_tracks = 7'(tracks); cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
        tick(); tick();
    endtask

    task automatic seg_start();
        exp_n = 0; mon_rd = 0;
    endtask

    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'h11}, {1'b1, 8'h22}, {1'b0, 8'h5C},
        {1'b1, 8'hA7}, {1'b1, 8'h03}, {1'b0, 8'hF0}
    };

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(!word_vld, "R1 word_vld", word_vld, 0);
        chk(!fifo_afull, "R1 fifo_afull", fifo_afull, 0);
        chk(!ovf_err, "R1 ovf_err", ovf_err, 0);
        chk(!mode_is64, "R1 mode_is64", mode_is64, 0);
        chk(!cfg_rej, "R1 cfg_rej", cfg_rej, 0);

        // Vector table (R3, R4, R5, R7)
        word_rdy = 1'b1;
        for (int v = 0; v < 6; v++) begin
            tb_m64 = VEC[v][8];
            do_cfg(VEC[v][8] ? 64 : 32);
            ph = 0;
            chk(mode_is64 == VEC[v][8], "R2 mode set", mode_is64, VEC[v][8]);
            seg_start();
            run = 1'b1; tick();
            for (int b = 0; b < 18; b++) send_bit(pat(int'(VEC[v][7:0]), b), b == 0);
            run = 1'b0;
            repeat (40) tick();
            chk(mon_rd == exp_n, "R3 word count", mon_rd, exp_n);
        end

        // R2 bad count refused
        tb_m64 = 1'b1;
        cfg_tracks = 7'd48; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
        chk(cfg_rej, "R2 reject 48", cfg_rej, 1);
        chk(!mode_is64, "R2 mode kept", mode_is64, 0);
        tick();
        chk(!cfg_rej, "R2 reject one cycle", cfg_rej, 0);

        // R2/R11 write while running refused
        run = 1'b1; tick();
        cfg_tracks = 7'd64; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
        chk(cfg_rej, "R2 reject in run", cfg_rej, 1);
        chk(!mode_is64, "R2 mode kept in run", mode_is64, 0);
        run = 1'b0; tick();

        // R6 bits ignored in idle
        for (int b = 0; b < 5; b++) begin
            trk_in = pat(9, b); bit_en = 1'b1; tick(); bit_en = 1'b0; tick();
        end
        tick();
        chk(!word_vld, "R6 idle ignored", word_vld, 0);

        // R8/R9 fill with no reader, 32-track mode
        tb_m64 = 1'b0;
        word_rdy = 1'b0;
        seg_start();
        run = 1'b1; tick();
        for (int b = 0; b < 14; b++) send_bit(pat(77, b), b == 0);
        chk(!fifo_afull, "R8 afull at 13", fifo_afull, 0);
        send_bit(pat(77, 14), 1'b0);
        chk(fifo_afull, "R8 afull at 14", fifo_afull, 1);
        send_bit(pat(77, 15), 1'b0);
        send_bit(pat(77, 16), 1'b0);
        chk(!ovf_err, "R9 no ovf at 16", ovf_err, 0);
        send_bit(pat(77, 17), 1'b0);
        chk(!ovf_err, "R3 parity slot no push", ovf_err, 0);
        send_bit(pat(77, 18), 1'b0);
        chk(ovf_err, "R9 ovf set", ovf_err, 1);
        exp_n = 16;
        run = 1'b0; tick();
        word_rdy = 1'b1;
        repeat (40) tick();
        chk(mon_rd == 16, "R9 dropped word absent", mon_rd, 16);
        chk(ovf_err, "R9 ovf sticky", ovf_err, 1);

        // R10 flush on accepted config
        word_rdy = 1'b0;
        seg_start();
        run = 1'b1; tick();
        for (int b = 0; b < 3; b++) send_bit(pat(5, b), b == 0);
        run = 1'b0; tick();
        chk(word_vld, "R7 words held", word_vld, 1);
        do_cfg(64);
        tb_m64 = 1'b1;
        chk(!word_vld, "R10 flushed", word_vld, 0);
        chk(mode_is64, "R2 mode 64", mode_is64, 1);
        chk(ovf_err, "R9 ovf survives flush", ovf_err, 1);

        // R10 phase reset: 9 bits without frame_start -> 16 words
        word_rdy = 1'b1;
        seg_start(); ph = 0;
        run = 1'b1; tick();
        for (int b = 0; b < 9; b++) send_bit(pat(31, b), 1'b0);
        run = 1'b0;
        repeat (30) tick();
        chk(mon_rd == 16, "R10 phase reset count", mon_rd, 16);

        // R3 realign mid-group with frame_start
        seg_start();
        run = 1'b1; tick();
        for (int b = 0; b < 3; b++) send_bit(pat(44, b), b == 0);
        for (int b = 0; b < 9; b++) send_bit(pat(45, b), b == 0);
        run = 1'b0;
        repeat (30) tick();
        chk(mon_rd == 22, "R3 realign count", mon_rd, 22);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule